// File: doc/BRIEF.md
# UART Transmit-Ready, Transmit-Empty and Receive-Error Summary Flags

This block produces three bits of a UART line status word: the flag saying the transmit holding stage can take another character (THRE), the flag saying the whole transmit path is idle (TEMT), and a sticky summary saying that the receive queue holds at least one character tagged with a parity, framing or break condition. It does not hold any data. Instead it follows single-cycle event strobes from the neighbouring logic: CPU writes to the holding stage, moves of a character into the shift register, the end of a shift, pushes and pops on the receive queue with their error tag, line status reads, and queue flushes.

The flags behave differently in the two operating modes. With queueing off, the holding stage is a single register, and the summary bit is held at 0. With queueing on, the holding stage is a queue of `TX_DEPTH` entries. The summary bit then comes from a count of tagged entries in the receive queue, so a status read cannot clear it while such entries are still queued. Every event input is a one-cycle strobe with no back-pressure: the block accepts an event in the cycle it is presented. All three outputs are registered and show the effect of an event right after the clock edge that samples it.

Top module: `uart_lsr_flags`

## Requirements
- R1: After reset, `thre` = 1, `temt` = 1 and `rx_err_flag` = 0.
- R2: With `fifo_mode` = 0, a `thr_write` drives `thre` to 0 at the next edge. A `tsr_load` while the holding register is full drives it to 1. A write and a load in the same cycle leave `thre` at 0.
- R3: With `fifo_mode` = 1, `thre` is 1 exactly when the transmit queue is empty after all of that cycle's writes and loads. A write to a full queue (`TX_DEPTH` entries) is dropped.
- R4: `temt` is 1 only when the holding stage is empty and no character is in the shift register; otherwise it is 0.
- R5: A `tsr_load` while the holding stage is empty is ignored. When `tsr_load` and `tsr_done` fall in the same cycle, the shift register stays occupied.
- R6: With `fifo_mode` = 0, `rx_err_flag` stays 0 whatever the receive tags are.
- R7: With `fifo_mode` = 1, a push with `rx_push_err` = 1 sets `rx_err_flag` at the next edge.
- R8: `lsr_read` clears `rx_err_flag` unless tagged entries are still queued after that cycle's pop. The flag stays set after the last tagged entry is popped, until a read arrives.
- R9: `tx_clear` empties the transmit holding stage (so `thre` = 1) and leaves the shift register as it is. In the same cycle it overrides any write or load.
- R10: `rx_clear` zeroes the tagged-entry count and `rx_err_flag`. A change of `fifo_mode` clears both the transmit holding stage and the receive error state.
- R11: `lsr_test_wr` with `fifo_mode` = 0 (and no write or load that cycle) loads `lsr_test_thre` into `thre`. With `fifo_mode` = 1 it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 = queues enabled, 0 = single holding register |
| thr_write | input | 1 | CPU writes a character to the holding stage |
| tsr_load | input | 1 | Character moves from the holding stage to the shift register |
| tsr_done | input | 1 | Shift register finished sending its character |
| tx_clear | input | 1 | Flush the transmit holding stage |
| rx_push | input | 1 | Character pushed into the receive queue |
| rx_push_err | input | 1 | Error tag of the pushed character |
| rx_pop | input | 1 | Character popped from the receive queue |
| rx_pop_err | input | 1 | Error tag of the popped character |
| lsr_read | input | 1 | CPU reads the line status word |
| rx_clear | input | 1 | Flush the receive queue |
| lsr_test_wr | input | 1 | Test write of the line status word |
| lsr_test_thre | input | 1 | THRE value carried by the test write |
| thre | output | 1 | Transmit holding stage ready |
| temt | output | 1 | Transmit path fully empty |
| rx_err_flag | output | 1 | Error-tagged character(s) in receive queue |

## Verification
The embedded properties assume that the neighbouring logic reports tags truthfully. A pop carries `rx_pop_err` = 1 only for a character that was pushed with its tag set. `tsr_done` is raised only while a character is actually shifting. Receive pushes never exceed the queue depth. The stimulus keeps to these rules by replaying, in order, pops that match the tags pushed earlier, and by raising `tsr_done` only after a successful load. Flushes and mode changes are treated as events that reset every count.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  typedef struct packed {
    logic wr;
    logic ld;
    logic done;
    logic flush;
  } tx_evt_t;

  typedef struct packed {
    logic push_err;
    logic pop_err;
    logic flush;
  } rx_evt_t;

  function automatic int unsigned cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/uart_lsr_tx_track.sv
module uart_lsr_tx_track
  import uart_lsr_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fifo_mode,
  input  tx_evt_t ev,
  input  logic    test_wr,
  input  logic    test_thre,
  output logic    thre_o,
  output logic    temt_o
);
  localparam int unsigned CW = cnt_bits(TX_DEPTH);

  logic [CW-1:0] cnt_q, cnt_n, cap;
  logic          busy_q, busy_n;
  logic          thre_q, thre_n, temt_q, temt_n;
  logic          ld_ok, wr_ok;

  always_comb begin
    cap   = fifo_mode ? CW'(TX_DEPTH) : CW'(1);
    ld_ok = ev.ld && (cnt_q != '0) && !ev.flush;
    wr_ok = ev.wr && !ev.flush;
    cnt_n = cnt_q;
    if (ev.flush) begin
      cnt_n = '0;
    end else begin
      if (ld_ok) cnt_n = cnt_n - CW'(1);
      if (wr_ok && (cnt_n < cap)) cnt_n = cnt_n + CW'(1);
    end
    if (ld_ok)        busy_n = 1'b1;
    else if (ev.done) busy_n = 1'b0;
    else              busy_n = busy_q;
    if (ev.flush)         thre_n = 1'b1;
    else if (fifo_mode)   thre_n = (cnt_n == '0);
    else if (wr_ok)       thre_n = 1'b0;
    else if (ld_ok)       thre_n = 1'b1;
    else if (test_wr)     thre_n = test_thre;
    else                  thre_n = thre_q;
    temt_n = (cnt_n == '0) && !busy_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      thre_q <= 1'b1;
      temt_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      thre_q <= thre_n;
      temt_q <= temt_n;
    end
  end

  assign thre_o = thre_q;
  assign temt_o = temt_q;

  // R3
  tx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TX_DEPTH));

  // R2
  wr_clears_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.wr && !ev.flush) |=> !thre_o);

  // R4
  temt_needs_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode |=> (!temt_o || thre_o));

  // R5
  idle_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.ld && (cnt_q == '0) && !ev.wr && !ev.done && !ev.flush) |=> $stable(temt_o));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.flush |=> thre_o);
endmodule

// File: rtl/uart_lsr_rx_err.sv
module uart_lsr_rx_err
  import uart_lsr_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fifo_mode,
  input  rx_evt_t ev,
  input  logic    lsr_read,
  output logic    err_o
);
  localparam int unsigned CW = cnt_bits(RX_DEPTH);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          err_q, err_n;

  always_comb begin
    cnt_n = cnt_q;
    if (ev.flush) begin
      cnt_n = '0;
    end else begin
      if (ev.pop_err && (cnt_n != '0)) cnt_n = cnt_n - CW'(1);
      if (ev.push_err && (cnt_n < CW'(RX_DEPTH))) cnt_n = cnt_n + CW'(1);
    end
    if (!fifo_mode || ev.flush) err_n = 1'b0;
    else                        err_n = (err_q && !lsr_read) || (cnt_n != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      err_q <= err_n;
    end
  end

  assign err_o = err_q;

  // R7
  rx_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(RX_DEPTH));

  // R6
  no_err_plain_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> !err_o);

  // R7
  tag_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && ev.push_err && !ev.flush) |=> err_o);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && err_o && !lsr_read && !ev.flush) |=> err_o);
endmodule

// File: rtl/uart_lsr_flags.sv
module uart_lsr_flags
  import uart_lsr_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic thr_write,
  input  logic tsr_load,
  input  logic tsr_done,
  input  logic tx_clear,
  input  logic rx_push,
  input  logic rx_push_err,
  input  logic rx_pop,
  input  logic rx_pop_err,
  input  logic lsr_read,
  input  logic rx_clear,
  input  logic lsr_test_wr,
  input  logic lsr_test_thre,
  output logic thre,
  output logic temt,
  output logic rx_err_flag
);
  logic    mode_q, mode_chg;
  tx_evt_t tx_ev;
  rx_evt_t rx_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode;
  end

  assign mode_chg = (fifo_mode != mode_q);

  always_comb begin
    tx_ev.wr       = thr_write;
    tx_ev.ld       = tsr_load;
    tx_ev.done     = tsr_done;
    tx_ev.flush    = tx_clear || mode_chg;
    rx_ev.push_err = rx_push && rx_push_err;
    rx_ev.pop_err  = rx_pop && rx_pop_err;
    rx_ev.flush    = rx_clear || mode_chg;
  end

  uart_lsr_tx_track #(.TX_DEPTH(TX_DEPTH)) tx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_mode),
    .ev        (tx_ev),
    .test_wr   (lsr_test_wr),
    .test_thre (lsr_test_thre),
    .thre_o    (thre),
    .temt_o    (temt)
  );

  uart_lsr_rx_err #(.RX_DEPTH(RX_DEPTH)) rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_mode),
    .ev        (rx_ev),
    .lsr_read  (lsr_read),
    .err_o     (rx_err_flag)
  );

  // R10
  mode_flip_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (thre && !rx_err_flag));
endmodule

// File: tb/uart_lsr_flags_tb_top.sv
`timescale 1ns/1ps
module uart_lsr_flags_tb_top;
  localparam int DEPTH = 16;
  // stimulus bit masks: mode wr ld done ctx push ptag pop otag rd crx
  localparam logic [10:0] M  = 11'b10000000000;
  localparam logic [10:0] WR = 11'b01000000000;
  localparam logic [10:0] LD = 11'b00100000000;
  localparam logic [10:0] DN = 11'b00010000000;
  localparam logic [10:0] CT = 11'b00001000000;
  localparam logic [10:0] PT = 11'b00000110000;
  localparam logic [10:0] RD = 11'b00000000010;

  // {stimulus[10:0], exp thre, exp temt, exp err}
  localparam int NV = 28;
  localparam logic [13:0] VEC [NV] = '{
    14'b0100_0000_000_000, 14'b0010_0000_000_100, 14'b0100_0000_000_000,
    14'b0110_0000_000_000, 14'b0001_0000_000_000, 14'b0010_0000_000_100,
    14'b0001_0000_000_110, 14'b0000_0110_000_110, 14'b1000_0000_000_110,
    14'b1100_0000_000_000, 14'b1100_0000_000_000, 14'b1010_0000_000_000,
    14'b1110_0000_000_000, 14'b1010_0000_000_100, 14'b1001_0000_000_110,
    14'b1000_0110_000_111, 14'b1000_0110_000_111, 14'b1000_0000_010_111,
    14'b1000_0001_100_111, 14'b1000_0001_100_111, 14'b1000_0000_010_110,
    14'b1000_0100_000_110, 14'b1000_0110_010_111, 14'b1000_0001_110_110,
    14'b1000_0110_000_111, 14'b1000_0000_001_110, 14'b1100_0000_000_000,
    14'b1000_1000_000_110
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_mode = 0, thr_write = 0, tsr_load = 0, tsr_done = 0, tx_clear = 0;
  logic rx_push = 0, rx_push_err = 0, rx_pop = 0, rx_pop_err = 0;
  logic lsr_read = 0, rx_clear = 0, lsr_test_wr = 0, lsr_test_thre = 0;
  logic thre, temt, rx_err_flag;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_lsr_flags #(.TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .thr_write(thr_write),
    .tsr_load(tsr_load), .tsr_done(tsr_done), .tx_clear(tx_clear),
    .rx_push(rx_push), .rx_push_err(rx_push_err), .rx_pop(rx_pop),
    .rx_pop_err(rx_pop_err), .lsr_read(lsr_read), .rx_clear(rx_clear),
    .lsr_test_wr(lsr_test_wr), .lsr_test_thre(lsr_test_thre),
    .thre(thre), .temt(temt), .rx_err_flag(rx_err_flag)
  );

  task automatic check(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  // apply one cycle of stimulus at the falling edge, sample 1 ns after the rising edge
  task automatic step(input logic [10:0] s);
    @(negedge clk);
    {fifo_mode, thr_write, tsr_load, tsr_done, tx_clear, rx_push, rx_push_err,
     rx_pop, rx_pop_err, lsr_read, rx_clear} = s;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {fifo_mode, thr_write, tsr_load, tsr_done, tx_clear, rx_push, rx_push_err,
     rx_pop, rx_pop_err, lsr_read, rx_clear} = '0;
    lsr_test_wr = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    // R1 reset state
    check("R1", "thre", thre, 1'b1);
    check("R1", "temt", temt, 1'b1);
    check("R1", "err", rx_err_flag, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13:3]);
      check(VEC[i][13] ? "R3" : "R2", $sformatf("row %0d thre", i), thre, VEC[i][2]);
      check("R4", $sformatf("row %0d temt", i), temt, VEC[i][1]);
      check(VEC[i][13] ? "R8" : "R6", $sformatf("row %0d err", i), rx_err_flag, VEC[i][0]);
    end

    // R3 full queue drops the extra write
    do_reset();
    step(M);
    for (int i = 0; i < DEPTH + 1; i++) step(M | WR);
    for (int i = 0; i < DEPTH - 1; i++) step(M | LD);
    check("R3", "thre one entry left", thre, 1'b0);
    step(M | LD);
    check("R3", "thre after last load", thre, 1'b1);
    check("R4", "temt while shifting", temt, 1'b0);
    step(M | DN);
    check("R4", "temt idle", temt, 1'b1);

    // R5 load on empty stage ignored; load beats done
    step(M | LD);
    check("R5", "temt after idle load", temt, 1'b1);
    step(M | WR);
    step(M | LD);
    step(M | WR);
    step(M | LD | DN);
    check("R5", "temt load+done", temt, 1'b0);
    step(M | DN);
    check("R5", "temt after done", temt, 1'b1);

    // R9 clear beats write; shift register untouched
    step(M | WR | CT);
    check("R9", "thre clear+write", thre, 1'b1);
    step(M | WR);
    step(M | LD);
    step(M | WR);
    step(M | CT);
    check("R9", "thre after clear", thre, 1'b1);
    check("R9", "temt shift kept", temt, 1'b0);
    step(M | DN);

    // R7 tagged push; R10 mode change clears everything
    step(M | PT);
    check("R7", "err after tagged push", rx_err_flag, 1'b1);
    step(M | WR);
    step(M | WR);
    step('0);
    check("R10", "err after mode change", rx_err_flag, 1'b0);
    check("R10", "thre after mode change", thre, 1'b1);
    step(M);
    check("R10", "err back in queue mode", rx_err_flag, 1'b0);

    // R11 test write
    do_reset();
    step(WR);
    @(negedge clk);
    thr_write = 0; lsr_test_wr = 1; lsr_test_thre = 1;
    @(posedge clk); #1;
    check("R11", "thre test write plain mode", thre, 1'b1);
    @(negedge clk);
    lsr_test_wr = 0;
    step(M);
    step(M | WR);
    @(negedge clk);
    thr_write = 0; lsr_test_wr = 1; lsr_test_thre = 1;
    @(posedge clk); #1;
    check("R11", "thre test write queue mode", thre, 1'b0);
    @(negedge clk);
    lsr_test_wr = 0;

    // R8 read with tagged entries still present
    step(M | PT);
    step(M | RD);
    check("R8", "err survives read", rx_err_flag, 1'b1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule